// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. Register-programmed segment lengths define each line and each frame. Every line is built from four segments in a fixed order: sync pulse, back porch, active region, front porch. Every frame is built from lines in the same order. Each length is written as its count minus one.

A divider derives a pixel strobe from the system clock, and the counters advance only on that strobe. The outputs are:

- active-high horizontal and vertical sync;
- a data-enable;
- the coordinates of the current active pixel;
- two sticky interrupt status levels, one for frame start and one for a programmable line.

Software writes registers through a plain strobe port (`cfg_we`, `cfg_addr`, `cfg_wdata`). The port has no back-pressure: every write lands at the clock edge on which `cfg_we` is sampled high. The block has no streaming data path, so no valid/ready handshake exists. A video-enable request only takes effect at a frame boundary, so a frame that is already being scanned is never cut short. A soft-reset command returns the scan to the start of the vertical sync.

Top module: `raster_timing_gen`

## Requirements
- R1: After the reset input is released, hsync, vsync, de, px_x, px_y, irq_frame and irq_line are all 0. Video is off until a frame boundary finds the video request set.
- R2: Within a line, pixel strobes cover four segments in order: sync, back porch, active, front porch. The segment lengths are the codes at addresses 1, 2, 3 and 4 plus one, each a count of pixel strobes.
- R3: The vertical counter advances once per completed line. It passes through the same four segments, with lengths given by the codes at addresses 5, 6, 7 and 8 plus one, counted in lines.
- R4: hsync is high during the horizontal sync segment and vsync is high during the vertical sync segment. de is high only when both counters are in their active segments. During de, px_x and px_y give the pixel and line index within the active area; otherwise both are 0.
- R5: Bit 0 of address 0 is the video request. Video on/off is taken from it only at the frame boundary, which is the strobe that leaves the last front-porch pixel of the last line. While video is off, hsync, vsync and de stay 0 and the counters keep running.
- R6: At each frame boundary, status bit 0 (address 11) is set when enable register (address 10) bit 0 (global) and bit 1 (frame) are both 1. irq_frame shows status bit 0.
- R7: Status bit 1 is set on the pixel strobe that ends the first pixel of the active line whose index equals the threshold at address 9. It is gated by enable bit 0 and bit 2 (line). irq_line shows status bit 1.
- R8: Writing a 1 to a bit at address 11 clears that status bit, and a 0 leaves it unchanged. A set arriving on the same edge as a clear wins.
- R9: With divider code C (address 12), pix_stb is high once every C+1 clocks, and C = 0 gives a strobe on every clock. The counters move only on pix_stb.
- R10: A divider write above 254 stores 254, giving a divide ratio of 255.
- R11: Writing address 0 with bit 1 set performs a soft reset. Both counters go to the start of vertical sync, status is cleared and video turns off. Bit 1 itself is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pix_stb | output | 1 | Pixel strobe from the divider |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| px_x | output | 12 | Active pixel index in the line |
| px_y | output | 12 | Active line index in the frame |
| irq_frame | output | 1 | Frame-start status level |
| irq_line | output | 1 | Line-threshold status level |

## Verification
The embedded properties check the following on every cycle:

- segments advance strictly in cyclic order;
- data-enable never overlaps a sync pulse;
- video on/off changes only with the counters at the frame origin;
- status bits rise only when their enables allow it;
- the divider never strobes on two consecutive cycles with a nonzero code;
- oversized divider writes are clamped;
- a soft reset leaves the scan at the origin with status cleared.

Only the bench's scenarios can show the exact segment lengths, the coordinate values, the frame on which a mid-frame enable change appears, where the line interrupt lands, and the measured divider periods. The bench shows these by comparing every cycle against an arithmetic model under two timing configurations.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  localparam int NUM_SEG = 4;
  localparam int NUM_AXIS = 2;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_HBASE  = 4'd1;
  localparam logic [3:0] A_VBASE  = 4'd5;
  localparam logic [3:0] A_LTHR   = 4'd9;
  localparam logic [3:0] A_IRQEN  = 4'd10;
  localparam logic [3:0] A_IRQST  = 4'd11;
  localparam logic [3:0] A_DIV    = 4'd12;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [3:0]                     wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic                           en_req,
  output logic                           srst,
  output logic [NUM_SEG-1:0][CNT_W-1:0]  h_len,
  output logic [NUM_SEG-1:0][CNT_W-1:0]  v_len,
  output logic [CNT_W-1:0]               line_thr,
  output logic                           irq_glb,
  output logic                           irq_frm_en,
  output logic                           irq_ln_en,
  output logic [1:0]                     st_clr,
  output logic [DIV_W-1:0]               div_code
);
  localparam int DIV_MAX = (1 << DIV_W) - 2;
  localparam logic [DATA_W-1:0] DIV_MAX_D = DATA_W'(DIV_MAX);

  assign srst   = wr_en && (wr_addr == A_CTRL) && wr_data[1];
  assign st_clr = (wr_en && (wr_addr == A_IRQST)) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req     <= 1'b0;
      h_len      <= '0;
      v_len      <= '0;
      line_thr   <= '0;
      irq_glb    <= 1'b0;
      irq_frm_en <= 1'b0;
      irq_ln_en  <= 1'b0;
      div_code   <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (wr_addr == 4'(A_HBASE + i)) h_len[i] <= wr_data[CNT_W-1:0];
        if (wr_addr == 4'(A_VBASE + i)) v_len[i] <= wr_data[CNT_W-1:0];
      end
      if (wr_addr == A_CTRL) en_req <= wr_data[0];
      if (wr_addr == A_LTHR) line_thr <= wr_data[CNT_W-1:0];
      if (wr_addr == A_IRQEN) begin
        irq_glb    <= wr_data[0];
        irq_frm_en <= wr_data[1];
        irq_ln_en  <= wr_data[2];
      end
      if (wr_addr == A_DIV)
        div_code <= (wr_data > DIV_MAX_D) ? DIV_W'(DIV_MAX) : wr_data[DIV_W-1:0];
    end
  end

  // R10
  div_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == A_DIV && wr_data > DIV_MAX_D) |-> div_code == DIV_W'(DIV_MAX));
endmodule

// File: rtl/raster_clkdiv.sv
module raster_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [DIV_W-1:0] code,
  output logic             pix_stb
);
  logic [DIV_W-1:0] cnt;

  assign pix_stb = (cnt >= code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (srst || pix_stb) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R9
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && code != '0) |=> (!pix_stb || code == '0));
endmodule

// File: rtl/raster_axis.sv
module raster_axis
  import raster_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          step,
  input  logic [NUM_SEG-1:0][CNT_W-1:0] len,
  output seg_e                          seg,
  output logic [CNT_W-1:0]              cnt,
  output logic                          wrap
);
  seg_e             nxt_seg;
  logic [CNT_W-1:0] nxt_cnt;

  always_comb begin
    nxt_seg = seg;
    nxt_cnt = cnt;
    wrap    = 1'b0;
    if (step) begin
      if (cnt >= len[seg]) begin
        nxt_cnt = '0;
        nxt_seg = seg_e'(seg + 2'd1);
        wrap    = (seg == SEG_FRONT);
      end else begin
        nxt_cnt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_SYNC;
      cnt <= '0;
    end else if (clr) begin
      seg <= SEG_SYNC;
      cnt <= '0;
    end else begin
      seg <= nxt_seg;
      cnt <= nxt_cnt;
    end
  end

  // R2 R3
  seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && seg != $past(seg)) |-> seg == seg_e'($past(seg) + 2'd1));
endmodule

// File: rtl/raster_irq.sv
module raster_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       glb,
  input  logic       frm_en,
  input  logic       ln_en,
  input  logic       frame_evt,
  input  logic       line_evt,
  input  logic [1:0] clr,
  output logic [1:0] stat
);
  logic [1:0] set;

  assign set = {line_evt & glb & ln_en, frame_evt & glb & frm_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat <= 2'b00;
    else if (srst) stat <= 2'b00;
    else           stat <= (stat & ~clr) | set;
  end

  // R6
  frm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(glb && frm_en && frame_evt));

  // R7
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(glb && ln_en && line_evt));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pix_stb,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  px_x,
  output logic [CNT_W-1:0]  px_y,
  output logic              irq_frame,
  output logic              irq_line
);
  logic                          en_req, srst;
  logic [NUM_SEG-1:0][CNT_W-1:0] h_len, v_len;
  logic [CNT_W-1:0]              line_thr;
  logic                          irq_glb, irq_frm_en, irq_ln_en;
  logic [1:0]                    st_clr, stat;
  logic [DIV_W-1:0]              div_code;

  logic [NUM_SEG-1:0][CNT_W-1:0] len_a [NUM_AXIS];
  seg_e                          seg_a [NUM_AXIS];
  logic [CNT_W-1:0]              cnt_a [NUM_AXIS];
  logic                          wrap_a [NUM_AXIS];
  logic                          step_a [NUM_AXIS];
  logic                          video_on, frame_evt, line_evt;

  raster_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .en_req(en_req), .srst(srst), .h_len(h_len), .v_len(v_len), .line_thr(line_thr),
    .irq_glb(irq_glb), .irq_frm_en(irq_frm_en), .irq_ln_en(irq_ln_en),
    .st_clr(st_clr), .div_code(div_code)
  );

  raster_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .srst(srst), .code(div_code), .pix_stb(pix_stb)
  );

  assign len_a[0]  = h_len;
  assign len_a[1]  = v_len;
  assign step_a[0] = pix_stb;
  assign step_a[1] = wrap_a[0];

  for (genvar g = 0; g < NUM_AXIS; g++) begin : g_axis
    raster_axis #(.CNT_W(CNT_W)) u_axis (
      .clk(clk), .rst_n(rst_n), .clr(srst), .step(step_a[g]), .len(len_a[g]),
      .seg(seg_a[g]), .cnt(cnt_a[g]), .wrap(wrap_a[g])
    );
  end

  assign frame_evt = wrap_a[0] && wrap_a[1] && !srst;
  assign line_evt  = pix_stb && !srst && seg_a[0] == SEG_SYNC && cnt_a[0] == '0 &&
                     seg_a[1] == SEG_ACT && cnt_a[1] == line_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         video_on <= 1'b0;
    else if (srst)      video_on <= 1'b0;
    else if (frame_evt) video_on <= en_req;
  end

  raster_irq u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .glb(irq_glb), .frm_en(irq_frm_en),
    .ln_en(irq_ln_en), .frame_evt(frame_evt), .line_evt(line_evt), .clr(st_clr), .stat(stat)
  );

  assign hsync     = video_on && seg_a[0] == SEG_SYNC;
  assign vsync     = video_on && seg_a[1] == SEG_SYNC;
  assign de        = video_on && seg_a[0] == SEG_ACT && seg_a[1] == SEG_ACT;
  assign px_x      = de ? cnt_a[0] : '0;
  assign px_y      = de ? cnt_a[1] : '0;
  assign irq_frame = stat[0];
  assign irq_line  = stat[1];

  // R4
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R5
  video_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on != $past(video_on)) |->
      (seg_a[0] == SEG_SYNC && cnt_a[0] == '0 && seg_a[1] == SEG_SYNC && cnt_a[1] == '0));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (cnt_a[0] == '0 && cnt_a[1] == '0 && !video_on && !irq_frame && !irq_line));
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  import raster_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pix_stb, hsync, vsync, de, irq_frame, irq_line;
  logic [11:0] px_x, px_y;

  always #5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_stb(pix_stb), .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
    .irq_frame(irq_frame), .irq_line(irq_line)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int HS, HB, HA, HF, VS, VB, VA, VF, THR;
  int hp = 0, vp = 0;
  bit von = 0, en_reg = 0, mon_on = 0;
  bit [2:0] ien = '0;
  bit [1:0] st = '0;
  bit p_srst = 0, p_en_ok = 0, p_en_v = 0, p_ien_ok = 0;
  bit [2:0] p_ien = '0;
  bit [1:0] p_clr = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == A_CTRL) begin p_en_ok = 1; p_en_v = d[0]; p_srst = d[1]; end
    if (a == A_IRQEN) begin p_ien_ok = 1; p_ien = d[2:0]; end
    if (a == A_IRQST) p_clr = d[1:0];
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_timing(input int hs, hb, ha, hf, vs, vb, va, vf, thr);
    HS = hs; HB = hb; HA = ha; HF = hf; VS = vs; VB = vb; VA = va; VF = vf; THR = thr;
    wreg(4'd1, 16'(hs - 1)); wreg(4'd2, 16'(hb - 1));
    wreg(4'd3, 16'(ha - 1)); wreg(4'd4, 16'(hf - 1));
    wreg(4'd5, 16'(vs - 1)); wreg(4'd6, 16'(vb - 1));
    wreg(4'd7, 16'(va - 1)); wreg(4'd8, 16'(vf - 1));
    wreg(A_LTHR, 16'(thr));
  endtask

  // Per-cycle comparison against the arithmetic model, then model advance
  always @(negedge clk) begin
    int ht, vt, ex, ey, nvp;
    bit ehs, evs, ede, fe, le;
    bit [1:0] set;
    ht = HS + HB + HA + HF;
    vt = VS + VB + VA + VF;
    if (mon_on) begin
      ehs = von && hp < HS;
      evs = von && vp < VS;
      ede = von && hp >= HS + HB && hp < HS + HB + HA && vp >= VS + VB && vp < VS + VB + VA;
      ex = ede ? hp - HS - HB : 0;
      ey = ede ? vp - VS - VB : 0;
      check(hsync == ehs, "R2 hsync", hsync, ehs);
      check(vsync == evs, "R3 vsync", vsync, evs);
      check(de == ede && int'(px_x) == ex && int'(px_y) == ey, "R4 de/x/y",
            {de, 8'(px_x), 8'(px_y)}, {ede, 8'(ex), 8'(ey)});
      check({irq_line, irq_frame} == st, "R6 R7 R8 status", {irq_line, irq_frame}, st);
      check(pix_stb == 1'b1, "R9 strobe at code 0", pix_stb, 1);
      fe = (hp == ht - 1) && (vp == vt - 1);
      le = (hp == 0) && (vp == VS + VB + THR) && (THR < VA);
      set = {le && ien[0] && ien[2], fe && ien[0] && ien[1]};
      if (!p_srst) begin
        st = (st & ~p_clr) | set;
        if (fe) von = en_reg;
        nvp = (hp == ht - 1) ? ((vp == vt - 1) ? 0 : vp + 1) : vp;
        hp = (hp == ht - 1) ? 0 : hp + 1;
        vp = nvp;
      end
    end
    if (p_srst) begin hp = 0; vp = 0; von = 0; st = '0; end
    else if (!mon_on) st = st & ~p_clr;
    if (p_en_ok) en_reg = p_en_v;
    if (p_ien_ok) ien = p_ien;
    p_srst = 0; p_en_ok = 0; p_ien_ok = 0; p_clr = '0;
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic measure(input int exp, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!pix_stb) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
    end while (!pix_stb && n < 400);
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int de_seen;
    HS = 1; HB = 1; HA = 1; HF = 1; VS = 1; VB = 1; VA = 1; VF = 1; THR = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({hsync, vsync, de, irq_frame, irq_line} == 5'b0 && px_x == 0 && px_y == 0,
          "R1 outputs after reset", {hsync, vsync, de, irq_frame, irq_line}, 0);
    de_seen = 0;
    repeat (40) begin @(negedge clk); de_seen += int'(de | hsync | vsync); end
    check(de_seen == 0, "R1 video off after reset", de_seen, 0);

    // Configuration A: 9 pixels per line, 7 lines per frame, threshold on last line
    cfg_timing(2, 1, 4, 2, 1, 2, 3, 1, 2);
    wreg(A_DIV, 16'd0);
    wreg(A_IRQEN, 16'h7);
    wreg(A_CTRL, 16'h3);   // R11 soft reset with video request
    mon_on = 1;
    @(negedge clk);
    check(irq_frame == 0 && irq_line == 0 && !de, "R11 state after soft reset", {irq_frame, irq_line}, 0);
    run(3 * 63);

    // R8 write-one-to-clear
    wreg(A_IRQST, 16'h1);
    run(20);
    wreg(A_IRQST, 16'h3);
    run(30);

    // R5 mid-frame withdrawal of the video request
    wait (vp == 4);
    wreg(A_CTRL, 16'h0);
    run(2 * 63);
    wreg(A_CTRL, 16'h1);
    run(2 * 63);

    // R6 R7 gating by global and per-source enables
    wreg(A_IRQEN, 16'h6);
    wreg(A_IRQST, 16'h3);
    run(2 * 63);
    wreg(A_IRQEN, 16'h3);
    run(2 * 63);

    // Configuration B: 11 pixels per line, 8 lines, threshold on first active line
    mon_on = 0;
    cfg_timing(1, 3, 6, 1, 2, 1, 2, 3, 0);
    wreg(A_IRQEN, 16'h7);
    wreg(A_CTRL, 16'h3);
    mon_on = 1;
    run(3 * 88);
    wait (vp == 3);
    wreg(A_CTRL, 16'h3);   // R11 mid-frame soft reset
    @(negedge clk);
    check(irq_frame == 0 && irq_line == 0 && !de && !hsync, "R11 mid-frame soft reset",
          {irq_frame, irq_line, de, hsync}, 0);
    run(2 * 88);
    mon_on = 0;

    // R9 R10 divider periods
    wreg(A_DIV, 16'd3);
    measure(4, "R9 divide by 4");
    wreg(A_DIV, 16'd1);
    measure(2, "R9 divide by 2");
    wreg(A_DIV, 16'd254);
    measure(255, "R9 divide by 255");
    wreg(A_DIV, 16'h00FF);
    measure(255, "R10 clamp of 0xFF");
    wreg(A_DIV, 16'h0FFF);
    measure(255, "R10 clamp of wide value");
    wreg(A_DIV, 16'd0);
    measure(1, "R9 no division");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule